// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the sequence of column addresses that a synchronous DRAM bank walks through during one read or write burst. A controller pulses a start strobe in the cycle its column command is issued, together with the start column, a three-bit length code and an ordering bit. Starting in the next cycle the block emits one column address per clock. Each address comes with a valid flag, and a last flag marks the final beat.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned group of that size that holds the start column. Within that group the beats run in either wrapping-increment order or XOR order. A full-page burst walks the whole column space, wrapping at the top, until the controller stops it. A stop or terminate input ends any burst early. A fresh start strobe replaces the running burst. Unusable settings raise an error pulse and produce no beats.

Top module: `burst_colgen`

## Requirements
- R1: Length code 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives full page. Codes 3'b100, 3'b101 and 3'b110 are reserved.
- R2: With the order bit at 0 (sequential), the low log2(BL) bits of the address count up modulo BL from the start column, and the upper bits stay those of the start column. For example, BL 4 from column 2 gives 2,3,0,1.
- R3: With the order bit at 1 (interleave), beat i carries the start column with its low log2(BL) bits XORed with i. For example, BL 8 from column 5 gives 5,4,7,6,1,0,3,2.
- R4: Full page with sequential order covers all 2^COL_W columns, wraps from the top column to 0, and never asserts the last flag.
- R5: The start column, code and order bit are sampled on the edge where the start strobe is high. The first beat, equal to the start column, is valid in the following cycle, and one beat follows per cycle after that.
- R6: For fixed lengths the last flag is high exactly on beat BL-1, and valid drops in the next cycle unless a new start was sampled.
- R7: A reserved code, or full page together with interleave order, raises the error flag for exactly one cycle after the start edge and produces no valid beat.
- R8: A start strobe sampled during an active burst abandons that burst, and the new start column appears in the next cycle.
- R9: A stop or terminate input sampled during an active burst, with no start on the same edge, makes valid low in the next cycle.
- R10: After reset, valid, last and error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, high on the column command cycle |
| start_col_i | input | COL_W | Start column |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | Order select: 0 sequential, 1 interleave |
| stop_i | input | 1 | Burst stop request |
| term_i | input | 1 | Terminate request from an interrupting command |
| col_o | output | COL_W | Current column address |
| valid_o | output | 1 | col_o carries a beat |
| last_o | output | 1 | Final beat of a fixed-length burst |
| err_o | output | 1 | One-cycle pulse for an unusable start |

## Verification
The bench builds the block with its default column width of 8. At that width the full page has 256 columns, so a start a few columns below 255 reaches the wrap to 0 within a handful of cycles. Every fixed length fits well inside the column space, so upper-bit preservation shows up with start columns that sit high in the space. Both orders and every length code, including the reserved ones, fit in short directed scenarios.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    localparam int COL_W_DEF = 8;

    localparam logic [2:0] LEN_1    = 3'b000;
    localparam logic [2:0] LEN_2    = 3'b001;
    localparam logic [2:0] LEN_4    = 3'b010;
    localparam logic [2:0] LEN_8    = 3'b011;
    localparam logic [2:0] LEN_FULL = 3'b111;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode #(
    parameter int COL_W = bcg_pkg::COL_W_DEF
) (
    input  logic [2:0]       code_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] mask_o,
    output logic             full_o,
    output logic             bad_o
);
    localparam logic [COL_W-1:0] ALL_ONES = '1;

    always_comb begin
        mask_o = '0;
        full_o = 1'b0;
        bad_o  = 1'b0;
        case (code_i)
            bcg_pkg::LEN_1,
            bcg_pkg::LEN_2,
            bcg_pkg::LEN_4,
            bcg_pkg::LEN_8: begin
                mask_o = COL_W'((32'd1 << code_i[1:0]) - 32'd1);
            end
            bcg_pkg::LEN_FULL: begin
                mask_o = ALL_ONES;
                full_o = 1'b1;
                bad_o  = ilv_i;
            end
            default: begin
                bad_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/bcg_addr_order.sv
module bcg_addr_order #(
    parameter int COL_W = bcg_pkg::COL_W_DEF
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] offs;

    always_comb begin
        if (ilv_i) begin
            offs = base_i ^ beat_i;
        end else begin
            offs = base_i + beat_i;
        end
    end

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col_o[b] = mask_i[b] ? offs[b] : base_i[b];
    end
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen #(
    parameter int COL_W = bcg_pkg::COL_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             ilv_i,
    input  logic             stop_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             err_o
);
    typedef struct packed {
        logic             active;
        logic             full;
        logic             ilv;
        logic             err;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] mask;
    } state_t;

    state_t st_d, st_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             dec_bad;
    logic             at_end;

    bcg_len_decode #(.COL_W(COL_W)) u_dec (
        .code_i (len_code_i),
        .ilv_i  (ilv_i),
        .mask_o (dec_mask),
        .full_o (dec_full),
        .bad_o  (dec_bad)
    );

    bcg_addr_order #(.COL_W(COL_W)) u_ord (
        .base_i (st_q.base),
        .beat_i (st_q.beat),
        .mask_i (st_q.mask),
        .ilv_i  (st_q.ilv),
        .col_o  (col_o)
    );

    assign at_end = st_q.active && !st_q.full && (st_q.beat == st_q.mask);

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (start_i) begin
            st_d.beat = '0;
            if (dec_bad) begin
                st_d.active = 1'b0;
                st_d.err    = 1'b1;
            end else begin
                st_d.active = 1'b1;
                st_d.base   = start_col_i;
                st_d.mask   = dec_mask;
                st_d.full   = dec_full;
                st_d.ilv    = ilv_i;
            end
        end else if (st_q.active) begin
            if (stop_i || term_i || at_end) begin
                st_d.active = 1'b0;
            end else begin
                st_d.beat = st_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.active;
    assign last_o  = at_end;
    assign err_o   = st_q.err;
endmodule

// File: rtl/burst_colgen_sva.sv
module burst_colgen_sva #(
    parameter int COL_W = bcg_pkg::COL_W_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [2:0]       len_code_i,
    input logic             ilv_i,
    input logic             stop_i,
    input logic             term_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             err_o
);
    logic usable;
    assign usable = (len_code_i[2] == 1'b0) || ((len_code_i == 3'b111) && !ilv_i);

    a_r5_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && usable) |=> (valid_o && col_o == $past(start_col_i)));

    a_r6_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);

    a_r6_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    a_r7_err_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !usable) |=> (err_o && !valid_o));

    a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !start_i) |=> !err_o);

    a_r9_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && (stop_i || term_i) && !start_i) |=> !valid_o);

    a_r4_full_no_last: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && len_code_i == 3'b111 && !ilv_i) |=> !last_o);
endmodule

bind burst_colgen burst_colgen_sva #(.COL_W(COL_W)) u_sva (.*);

// File: tb/burst_colgen_bench.sv
module burst_colgen_bench;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [CW-1:0] start_col_i = '0;
    logic [2:0]    len_code_i = '0;
    logic          ilv_i = 1'b0;
    logic          stop_i = 1'b0;
    logic          term_i = 1'b0;
    logic [CW-1:0] col_o;
    logic          valid_o, last_o, err_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    burst_colgen #(.COL_W(CW)) u_burst_colgen (.*);

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_col(int s, int bl, int i, bit ilv);
        int m = bl - 1;
        if (ilv) return (s & ~m) | ((s ^ i) & m);
        return ((s & ~m) | ((s + i) & m)) & 255;
    endfunction

    task automatic launch(int col, logic [2:0] code, bit ilv);
        @(negedge clk);
        start_i = 1'b1; start_col_i = CW'(col); len_code_i = code; ilv_i = ilv;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_fixed(string req, int col, logic [2:0] code, int bl, bit ilv);
        launch(col, code, ilv);
        for (int i = 0; i < bl; i++) begin
            check(req, int'(col_o), exp_col(col, bl, i, ilv));
            check("R5 valid", int'(valid_o), 1);
            check("R6 last", int'(last_o), (i == bl - 1) ? 1 : 0);
            @(negedge clk);
        end
        check("R6 valid drops", int'(valid_o), 0);
    endtask

    task automatic t_reset();
        check("R10 valid", int'(valid_o), 0);
        check("R10 last", int'(last_o), 0);
        check("R10 err", int'(err_o), 0);
    endtask

    task automatic t_lengths();
        run_fixed("R1 len1", 77, 3'b000, 1, 1'b0);
        run_fixed("R1 len2", 9, 3'b001, 2, 1'b0);
        run_fixed("R2 seq4", 2, 3'b010, 4, 1'b0);
        run_fixed("R2 seq8 upper", 205, 3'b011, 8, 1'b0);
        run_fixed("R3 ilv8", 5, 3'b011, 8, 1'b1);
        run_fixed("R3 ilv4", 250, 3'b010, 4, 1'b1);
        run_fixed("R3 ilv2", 33, 3'b001, 2, 1'b1);
    endtask

    task automatic t_full();
        launch(253, 3'b111, 1'b0);
        for (int i = 0; i < 6; i++) begin
            check("R4 full col", int'(col_o), (253 + i) % 256);
            check("R4 full no last", int'(last_o), 0);
            if (i == 5) stop_i = 1'b1;
            @(negedge clk);
        end
        stop_i = 1'b0;
        check("R9 stop ends full", int'(valid_o), 0);
    endtask

    task automatic t_term();
        launch(5, 3'b011, 1'b1);
        check("R9 beat0", int'(col_o), 5);
        @(negedge clk);
        check("R9 beat1", int'(col_o), 4);
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        check("R9 term ends", int'(valid_o), 0);
    endtask

    task automatic t_restart();
        launch(16, 3'b011, 1'b0);
        @(negedge clk);
        @(negedge clk);
        check("R8 before", int'(col_o), 18);
        start_i = 1'b1; start_col_i = 8'd42; len_code_i = 3'b010; ilv_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check("R8 restart col", int'(col_o), exp_col(42, 4, i, 1'b1));
            check("R8 restart last", int'(last_o), (i == 3) ? 1 : 0);
            @(negedge clk);
        end
        check("R8 end", int'(valid_o), 0);
    endtask

    task automatic t_errors();
        logic [2:0] codes [4] = '{3'b100, 3'b101, 3'b110, 3'b111};
        for (int k = 0; k < 4; k++) begin
            launch(12, codes[k], (k == 3));
            check("R7 err", int'(err_o), 1);
            check("R7 no beat", int'(valid_o), 0);
            @(negedge clk);
            check("R7 err pulse", int'(err_o), 0);
            check("R7 still idle", int'(valid_o), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lengths();
        t_full();
        t_term();
        t_restart();
        t_errors();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule